// File: doc/BRIEF.md
# Coprocessor Control and Interrupt Register

A single 16-bit control and status register that a host CPU uses to steer an audio coprocessor and to collect its interrupts. It holds four sticky status bits, for the audio interface, the auxiliary memory DMA engine, the coprocessor itself and the coprocessor's DMA. Each of these is set by a one-cycle event pulse from its source and is cleared by the host writing 1 to it. The first three sources each have a mask bit, and the host interrupt line is the registered OR of every status bit ANDed with its mask.

The same register drives three control outputs. A level halt holds the coprocessor stopped while it is set. A reset strobe fires for one cycle each time the host writes 1 to it. An interrupt request toward the coprocessor stays raised until the coprocessor acknowledges it. The host reaches the register through a simple byte-addressed write/read port. The register answers at offset 0x0A.

Top module: `coproc_ctrl_reg`

## Requirements
- R1: After reset every register bit is 0, and host_irq_o, halt_o, cop_rst_o and cop_irq_o are low.
- R2: Register layout at offset 0x0A: bit 0 reset strobe, bit 1 coprocessor request, bit 2 halt, bit 3 audio status, bit 4 audio mask, bit 5 memory status, bit 6 memory mask, bit 7 coprocessor status, bit 8 coprocessor mask, bit 9 coprocessor DMA status. Bit 0 and bits 15:10 always read 0.
- R3: A one-cycle event pulse on a source input sets that source's status bit on the next clock edge, and the bit stays set with no further pulse.
- R4: Writing 1 to a status bit clears it, and writing 0 to it leaves it unchanged.
- R5: If a source's event pulse and a write-1 clear of the same status bit occur in the same cycle, the bit ends set.
- R6: Mask bits are plain read/write. host_irq_o is 1 in a cycle exactly when, in the previous cycle, at least one of the audio, memory or coprocessor status bits was set together with its mask. The coprocessor DMA status has no mask and never drives host_irq_o.
- R7: host_irq_o stays high for the cycle after the write edge that clears the last enabled status bit, and goes low on the edge after that.
- R8: halt_o equals the halt bit, which follows the value last written to bit 2.
- R9: Writing 1 to bit 0 makes cop_rst_o high for exactly the one cycle after the write edge.
- R10: Writing 1 to bit 1 sets cop_irq_o. A pulse on pi_ack_i clears it, and writing 0 to bit 1 has no effect. A write of 1 in the same cycle as an acknowledge leaves it set.
- R11: Writes to any address other than 0x0A change nothing, and reads at any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Host byte address |
| wr_en_i | input | 1 | Host write strobe |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Host read data (combinational) |
| aud_evt_i | input | 1 | Audio interface event pulse |
| mem_evt_i | input | 1 | Memory DMA event pulse |
| cop_evt_i | input | 1 | Coprocessor event pulse |
| dma_evt_i | input | 1 | Coprocessor DMA event pulse |
| pi_ack_i | input | 1 | Coprocessor acknowledge of the request |
| host_irq_o | output | 1 | Registered host interrupt |
| halt_o | output | 1 | Coprocessor halt level |
| cop_rst_o | output | 1 | One-cycle coprocessor reset strobe |
| cop_irq_o | output | 1 | Interrupt request toward the coprocessor |

## Verification
The bench goes after the same-cycle collisions: an event arriving with its own clear, and an acknowledge arriving with a request write. A design that gave the clear or the acknowledge priority would drop the bit in those cases. It times the interrupt release edge by edge, so a combinational interrupt path, or one that lags an extra cycle, shows up as a mismatch. It also checks that the unmasked DMA status never raises the line, that writes at other offsets leave the register untouched, and that the reset strobe lasts one cycle and reads back 0. A latched strobe, a leaking address decode or a mask wired to the wrong source would each fail one of these checks.

// File: rtl/coproc_ctrl_pkg.sv
package coproc_ctrl_pkg;
  localparam int unsigned CSR_W    = 16;
  localparam int unsigned NUM_SRC  = 4;
  localparam int unsigned NUM_MSK  = 3;
  localparam int unsigned BIT_RES  = 0;
  localparam int unsigned BIT_PI   = 1;
  localparam int unsigned BIT_HALT = 2;
  localparam int unsigned TOP_BIT  = 9;

  typedef enum logic [1:0] {SRC_AUD, SRC_MEM, SRC_COP, SRC_DMA} src_e;

  function automatic int unsigned stat_pos(input int unsigned idx);
    return 3 + 2 * idx;
  endfunction

  function automatic int unsigned mask_pos(input int unsigned idx);
    return 4 + 2 * idx;
  endfunction
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell #(
  parameter bit HAS_MASK = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic mask_we_i,
  input  logic mask_d_i,
  output logic stat_o,
  output logic mask_o,
  output logic req_o
);
  logic stat_q;

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stat_q <= 1'b0;
    else if (set_i) stat_q <= 1'b1;
    else if (clr_i) stat_q <= 1'b0;
  end

  generate
    if (HAS_MASK) begin : g_mask
      logic mask_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        mask_q <= 1'b0;
        else if (mask_we_i) mask_q <= mask_d_i;
      end
      assign mask_o = mask_q;
    end else begin : g_nomask
      logic unused_mask;
      assign unused_mask = mask_we_i ^ mask_d_i;
      assign mask_o      = 1'b0;
    end
  endgenerate

  assign stat_o = stat_q;
  assign req_o  = stat_q & mask_o;
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |req_i;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/cop_ctrl_bits.sv
module cop_ctrl_bits (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_hit_i,
  input  logic res_d_i,
  input  logic pi_d_i,
  input  logic halt_d_i,
  input  logic ack_i,
  output logic halt_o,
  output logic pi_o,
  output logic rst_o
);
  logic halt_q, pi_q, rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q <= 1'b0;
      pi_q   <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_q <= wr_hit_i & res_d_i;
      if (wr_hit_i) halt_q <= halt_d_i;
      // host request beats acknowledge
      if (wr_hit_i && pi_d_i) pi_q <= 1'b1;
      else if (ack_i)         pi_q <= 1'b0;
    end
  end

  assign halt_o = halt_q;
  assign pi_o   = pi_q;
  assign rst_o  = rst_q;
endmodule

// File: rtl/coproc_ctrl_reg.sv
module coproc_ctrl_reg
  import coproc_ctrl_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 8,
  parameter logic [ADDR_W-1:0]    REG_ADDR = 8'h0A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [CSR_W-1:0]  wdata_i,
  output logic [CSR_W-1:0]  rdata_o,
  input  logic              aud_evt_i,
  input  logic              mem_evt_i,
  input  logic              cop_evt_i,
  input  logic              dma_evt_i,
  input  logic              pi_ack_i,
  output logic              host_irq_o,
  output logic              halt_o,
  output logic              cop_rst_o,
  output logic              cop_irq_o
);
  logic                 sel, wr_hit;
  logic [NUM_SRC-1:0]   evt, stat_q, mask_q, req;
  logic [CSR_W-1:0]     rd;
  logic                 pi_q;
  logic                 unused_hi;

  assign sel    = (addr_i == REG_ADDR);
  assign wr_hit = wr_en_i & sel;
  assign evt    = {dma_evt_i, cop_evt_i, mem_evt_i, aud_evt_i};
  assign unused_hi = |wdata_i[CSR_W-1:TOP_BIT+1];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam bit HM = (i < NUM_MSK);
    irq_src_cell #(.HAS_MASK(HM)) u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (evt[i]),
      .clr_i     (wr_hit & wdata_i[stat_pos(i)]),
      .mask_we_i (wr_hit & HM),
      .mask_d_i  (HM ? wdata_i[mask_pos(i)] : 1'b0),
      .stat_o    (stat_q[i]),
      .mask_o    (mask_q[i]),
      .req_o     (req[i])
    );
  end

  irq_combine #(.N(NUM_SRC)) u_comb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .irq_o  (host_irq_o)
  );

  cop_ctrl_bits u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_hit_i (wr_hit),
    .res_d_i  (wdata_i[BIT_RES]),
    .pi_d_i   (wdata_i[BIT_PI]),
    .halt_d_i (wdata_i[BIT_HALT]),
    .ack_i    (pi_ack_i),
    .halt_o   (halt_o),
    .pi_o     (pi_q),
    .rst_o    (cop_rst_o)
  );

  assign cop_irq_o = pi_q;

  always_comb begin
    rd           = '0;
    rd[BIT_PI]   = pi_q;
    rd[BIT_HALT] = halt_o;
    for (int i = 0; i < NUM_SRC; i++) begin
      rd[stat_pos(i)] = stat_q[i];
      if (i < NUM_MSK) rd[mask_pos(i)] = mask_q[i];
    end
  end

  assign rdata_o = sel ? rd : '0;
endmodule

// File: rtl/coproc_ctrl_reg_chk.sv
module coproc_ctrl_reg_chk #(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h0A
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [15:0]       wdata_i,
  input logic [15:0]       rdata_o,
  input logic              aud_evt_i,
  input logic              pi_ack_i,
  input logic              host_irq_o,
  input logic              halt_o,
  input logic              cop_rst_o,
  input logic              cop_irq_o,
  input logic [3:0]        stat_i,
  input logic [3:0]        mask_i
);
  logic hit;
  assign hit = wr_en_i && (addr_i == REG_ADDR);

  assert_zero_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[15:10] == 6'd0 && !rdata_o[0]);

  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aud_evt_i |=> stat_i[0]);

  assert_irq_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_irq_o == $past(|(stat_i[2:0] & mask_i[2:0])));

  assert_halt_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> (halt_o == $past(wdata_i[2])));

  assert_rst_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cop_rst_o |=> !cop_rst_o);

  assert_pi_ack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pi_ack_i && !(hit && wdata_i[1])) |=> !cop_irq_o);
endmodule

bind coproc_ctrl_reg coproc_ctrl_reg_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wr_en_i    (wr_en_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .aud_evt_i  (aud_evt_i),
  .pi_ack_i   (pi_ack_i),
  .host_irq_o (host_irq_o),
  .halt_o     (halt_o),
  .cop_rst_o  (cop_rst_o),
  .cop_irq_o  (cop_irq_o),
  .stat_i     (stat_q),
  .mask_i     (mask_q)
);

// File: tb/coproc_ctrl_reg_tb.sv
module coproc_ctrl_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = 8'h0A;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  evt = '0;
  logic        ack = 1'b0;
  logic        host_irq, halt, cop_rst, cop_irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  coproc_ctrl_reg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .aud_evt_i(evt[0]), .mem_evt_i(evt[1]), .cop_evt_i(evt[2]),
    .dma_evt_i(evt[3]), .pi_ack_i(ack), .host_irq_o(host_irq), .halt_o(halt),
    .cop_rst_o(cop_rst), .cop_irq_o(cop_irq)
  );

  // {wr, wdata, evt[dma,cop,mem,aud], ack, exp_rdata, exp_irq}
  localparam int NV = 14;
  localparam logic [38:0] VEC [NV] = '{
    {1'b1, 16'h0010, 4'h0, 1'b0, 16'h0010, 1'b0},
    {1'b0, 16'h0000, 4'h1, 1'b0, 16'h0018, 1'b1},
    {1'b1, 16'h0018, 4'h0, 1'b0, 16'h0010, 1'b0},
    {1'b0, 16'h0000, 4'h2, 1'b0, 16'h0030, 1'b0},
    {1'b1, 16'h0050, 4'h0, 1'b0, 16'h0070, 1'b1},
    {1'b1, 16'h0070, 4'h0, 1'b0, 16'h0050, 1'b0},
    {1'b0, 16'h0000, 4'hC, 1'b0, 16'h02D0, 1'b0},
    {1'b1, 16'h0150, 4'h0, 1'b0, 16'h03D0, 1'b1},
    {1'b1, 16'h0350, 4'h0, 1'b0, 16'h01D0, 1'b1},
    {1'b1, 16'h01D0, 4'h0, 1'b0, 16'h0150, 1'b0},
    {1'b1, 16'h0154, 4'h0, 1'b0, 16'h0154, 1'b0},
    {1'b1, 16'h0152, 4'h0, 1'b0, 16'h0152, 1'b0},
    {1'b0, 16'h0000, 4'h0, 1'b1, 16'h0150, 1'b0},
    {1'b1, 16'h0000, 4'h0, 1'b0, 16'h0000, 1'b0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // drive for one edge, then release
  task automatic step(input logic w, input logic [15:0] d, input logic [3:0] e, input logic a);
    @(negedge clk);
    wr = w; wdata = d; evt = e; ack = a;
    @(negedge clk);
    wr = 1'b0; wdata = '0; evt = '0; ack = 1'b0;
  endtask

  initial begin
    #(20 * 5000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    if (!done) begin
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata", rdata, 16'h0000);
    check("R1 outputs", {12'd0, host_irq, halt, cop_rst, cop_irq}, 16'h0000);

    // R2 R3 R4 R6 R8 R10 table walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][38], VEC[i][37:22], VEC[i][21:18], VEC[i][17]);
      @(negedge clk);
      check($sformatf("R2/R4/R6 vec%0d rdata", i), rdata, VEC[i][16:1]);
      check($sformatf("R6 vec%0d irq", i), {15'd0, host_irq}, {15'd0, VEC[i][0]});
    end

    // R9 reset strobe
    @(negedge clk); wr = 1'b1; wdata = 16'h0001;
    @(negedge clk); wr = 1'b0; wdata = '0;
    check("R9 strobe high", {15'd0, cop_rst}, 16'd1);
    check("R2 res reads 0", rdata, 16'h0000);
    @(negedge clk);
    check("R9 strobe low", {15'd0, cop_rst}, 16'd0);

    // R8 halt
    step(1'b1, 16'h0004, 4'h0, 1'b0);
    check("R8 halt set", {15'd0, halt}, 16'd1);
    step(1'b1, 16'h0000, 4'h0, 1'b0);
    check("R8 halt clr", {15'd0, halt}, 16'd0);

    // R7 release timing
    step(1'b1, 16'h0010, 4'h1, 1'b0);
    @(negedge clk);
    check("R3 aud set", rdata, 16'h0018);
    check("R7 irq high", {15'd0, host_irq}, 16'd1);
    @(negedge clk); wr = 1'b1; wdata = 16'h0018;
    @(negedge clk); wr = 1'b0; wdata = '0;
    check("R4 cleared", rdata, 16'h0010);
    check("R7 irq holds one cycle", {15'd0, host_irq}, 16'd1);
    @(negedge clk);
    check("R7 irq released", {15'd0, host_irq}, 16'd0);

    // R5 set beats clear
    step(1'b0, 16'h0000, 4'h1, 1'b0);
    step(1'b1, 16'h0018, 4'h1, 1'b0);
    check("R5 set wins", rdata, 16'h0018);
    step(1'b1, 16'h0018, 4'h0, 1'b0);
    step(1'b1, 16'h0000, 4'h0, 1'b0);

    // R6 dma status never raises irq
    step(1'b0, 16'h0000, 4'h8, 1'b0);
    @(negedge clk);
    check("R6 dma status", rdata, 16'h0200);
    check("R6 dma no irq", {15'd0, host_irq}, 16'd0);
    step(1'b1, 16'h0200, 4'h0, 1'b0);
    check("R4 dma cleared", rdata, 16'h0000);

    // R10 request / ack
    step(1'b1, 16'h0002, 4'h0, 1'b0);
    check("R10 req set", {15'd0, cop_irq}, 16'd1);
    step(1'b1, 16'h0000, 4'h0, 1'b0);
    check("R10 write0 no effect", {15'd0, cop_irq}, 16'd1);
    step(1'b1, 16'h0002, 4'h0, 1'b1);
    check("R10 write beats ack", {15'd0, cop_irq}, 16'd1);
    step(1'b0, 16'h0000, 4'h0, 1'b1);
    check("R10 ack clears", {15'd0, cop_irq}, 16'd0);

    // R2 high bits, R11 decode
    step(1'b1, 16'hFC00, 4'h0, 1'b0);
    check("R2 upper bits zero", rdata, 16'h0000);
    @(negedge clk); addr = 8'h08; wr = 1'b1; wdata = 16'h0154;
    @(negedge clk); wr = 1'b0; wdata = '0;
    check("R11 other addr reads 0", rdata, 16'h0000);
    addr = 8'h0A;
    #1;
    check("R11 other addr write ignored", rdata, 16'h0000);
    check("R11 halt untouched", {15'd0, halt}, 16'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule